// File: doc/BRIEF.md
# Multiplexed Six-Bit Pixel Output Port

This block sends one converted pixel value, either 10 or 12 bits wide, off chip over a six-pin bus in four master-clock phases. The upper half of the word is driven during phases 0 and 1, and the lower half during phases 2 and 3. Each half therefore stays on the pins for two consecutive clocks. In the narrow 10-bit mode the lower half is left-aligned on the pins, and the two lowest pins carry zero.

The port is controlled by a two-state machine. `ST_FLOAT` is entered from reset and whenever the line flag is high. In this state the output enable is low and the pins float. The transition `FLOAT_TO_DRIVE` fires on the first clock edge that samples the line flag low. It restarts the phase counter at 0 and loads the first word. `ST_DRIVE` then steps the phase counter 0→1→2→3→0. It takes a new result and a new width mode only on the wrap into phase 0 (`DRIVE_WRAP`), so one word never carries bits from two results. The transition `DRIVE_TO_FLOAT` fires on any edge that samples the line flag high. The enable and data registers update on the same edge, so a partly updated word is never driven.

Top module: `pix_nibble_port`

## Requirements
- R1: After reset, `pad_oe` is 0, `phase_o` is 0 and `pad_data` is 0.
- R2: On every edge that samples `line_flag` high, the port goes to `ST_FLOAT`: `pad_oe` becomes 0, `pad_bus` floats and `phase_o` becomes 0.
- R3: On the first edge that samples `line_flag` low in `ST_FLOAT`, `pad_oe` becomes 1 and `phase_o` becomes 0. The first half of the word loaded on that edge is driven.
- R4: While `line_flag` stays low in `ST_DRIVE`, `phase_o` advances by one per clock and wraps from 3 to 0.
- R5: In wide mode (`mode_wide`=1), result bits 11..6 appear on `pad_data[5:0]` in phases 0 and 1, and bits 5..0 appear in phases 2 and 3.
- R6: In narrow mode (`mode_wide`=0), bits 9..4 appear on `pad_data[5:0]` in phases 0 and 1. In phases 2 and 3, bits 3..0 appear on `pad_data[5:2]` and `pad_data[1:0]` is 0. Bits 11..10 are ignored.
- R7: The value on `pad_data` in phase 1 equals its value in phase 0, and the value in phase 3 equals its value in phase 2.
- R8: `res_data`, `res_valid` and `mode_wide` are sampled only on an edge that enters phase 0. Values presented on other edges do not change the word being sent.
- R9: If `res_valid` is 0 on the edge that enters phase 0, the previous word is sent again.
- R10: `pad_bus` equals `pad_data` when `pad_oe` is 1, and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_data | input | 12 | Conversion result; in narrow mode only bits 9..0 are used |
| res_valid | input | 1 | Result strobe, taken only on an edge entering phase 0 |
| mode_wide | input | 1 | 1 = 12-bit mapping, 0 = 10-bit mapping |
| line_flag | input | 1 | New-line flag; high floats the bus |
| pad_bus | output | 6 | Tristate pixel bus |
| pad_data | output | 6 | Registered value behind the pad drivers |
| pad_oe | output | 1 | Output enable for the pad drivers |
| phase_o | output | 2 | Current phase, 0 to 3 |

## Verification
The bench builds the block with its default parameters: a six-bit bus and two padding bits in narrow mode. With these values both the 12-bit and the 10-bit pin mappings can be observed directly, including the zeroed low pins and the ignored top result bits. A vector table runs each width mode through a complete float-to-drive sequence. Directed tests follow for back-to-back words, a strobe in the middle of a word, a missing strobe at the wrap, and the line flag rising in the middle of a word.

// File: rtl/pix_port_pkg.sv
package pix_port_pkg;
    typedef enum logic {
        ST_FLOAT = 1'b0,
        ST_DRIVE = 1'b1
    } port_state_e;

    localparam int PH_W = 2;
    localparam logic [PH_W-1:0] PH_FIRST = '0;
    localparam logic [PH_W-1:0] PH_LAST  = '1;
endpackage

// File: rtl/pix_half_sel.sv
module pix_half_sel #(
    parameter int BUS_W      = 6,
    parameter int NARROW_PAD = 2
) (
    input  logic [2*BUS_W-1:0] word_i,
    input  logic               wide_i,
    input  logic               upper_i,
    output logic [BUS_W-1:0]   half_o
);
    localparam int RES_W = 2 * BUS_W;
    localparam int NW    = RES_W - NARROW_PAD;

    logic [BUS_W-1:0] wide_hi, wide_lo, nar_hi, nar_lo;

    assign wide_hi = word_i[RES_W-1 -: BUS_W];
    assign wide_lo = word_i[BUS_W-1:0];
    assign nar_hi  = word_i[NW-1 -: BUS_W];

    generate
        if (NARROW_PAD == 0) begin : g_nopad
            assign nar_lo = word_i[BUS_W-1:0];
        end else begin : g_pad
            assign nar_lo = {word_i[NW-BUS_W-1:0], {NARROW_PAD{1'b0}}};
        end
    endgenerate

    always_comb begin
        unique case ({wide_i, upper_i})
            2'b11:   half_o = wide_hi;
            2'b10:   half_o = wide_lo;
            2'b01:   half_o = nar_hi;
            default: half_o = nar_lo;
        endcase
    end
endmodule

// File: rtl/pix_nibble_port.sv
module pix_nibble_port
    import pix_port_pkg::*;
#(
    parameter int BUS_W      = 6,
    parameter int NARROW_PAD = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*BUS_W-1:0]   res_data,
    input  logic                 res_valid,
    input  logic                 mode_wide,
    input  logic                 line_flag,
    output logic [BUS_W-1:0]     pad_bus,
    output logic [BUS_W-1:0]     pad_data,
    output logic                 pad_oe,
    output logic [PH_W-1:0]      phase_o
);
    localparam int RES_W = 2 * BUS_W;

    port_state_e      state_q, state_n;
    logic [PH_W-1:0]  phase_q, phase_n;
    logic [RES_W-1:0] word_q, word_n;
    logic             wide_q, wide_n;
    logic             load;
    logic [BUS_W-1:0] half_n;
    logic [BUS_W-1:0] data_q;
    logic             oe_q;

    // Next-state and word-load decision
    always_comb begin
        state_n = state_q;
        phase_n = phase_q;
        load    = 1'b0;
        unique case (state_q)
            ST_FLOAT: begin
                if (!line_flag) begin
                    state_n = ST_DRIVE;          // FLOAT_TO_DRIVE
                    phase_n = PH_FIRST;
                    load    = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (line_flag) begin
                    state_n = ST_FLOAT;          // DRIVE_TO_FLOAT
                    phase_n = PH_FIRST;
                end else begin
                    phase_n = phase_q + 1'b1;
                    load    = (phase_q == PH_LAST); // DRIVE_WRAP
                end
            end
            default: begin
                state_n = ST_FLOAT;
                phase_n = PH_FIRST;
            end
        endcase
        word_n = (load && res_valid) ? res_data : word_q;
        wide_n = load ? mode_wide : wide_q;
    end

    pix_half_sel #(
        .BUS_W      (BUS_W),
        .NARROW_PAD (NARROW_PAD)
    ) u_sel (
        .word_i  (word_n),
        .wide_i  (wide_n),
        .upper_i (~phase_n[PH_W-1]),
        .half_o  (half_n)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOAT;
            phase_q <= PH_FIRST;
            word_q  <= '0;
            wide_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            phase_q <= phase_n;
            word_q  <= word_n;
            wide_q  <= wide_n;
        end
    end

    // Output process: enable and data change on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            data_q <= '0;
        end else begin
            oe_q   <= (state_n == ST_DRIVE);
            data_q <= (state_n == ST_DRIVE) ? half_n : '0;
        end
    end

    assign pad_oe   = oe_q;
    assign pad_data = data_q;
    assign phase_o  = phase_q;
    assign pad_bus  = oe_q ? data_q : {BUS_W{1'bz}};

    // R2
    property p_float_on_line;
        @(posedge clk) disable iff (!rst_n) line_flag |=> (!pad_oe && phase_o == PH_FIRST);
    endproperty
    float_on_line_chk: assert property (p_float_on_line);

    // R4
    property p_phase_step;
        @(posedge clk) disable iff (!rst_n)
            (pad_oe && !line_flag) |=> (phase_o == PH_W'($past(phase_o) + 1'b1));
    endproperty
    phase_step_chk: assert property (p_phase_step);

    // R7
    property p_half_repeat;
        @(posedge clk) disable iff (!rst_n) (pad_oe && phase_o[0]) |-> $stable(pad_data);
    endproperty
    half_repeat_chk: assert property (p_half_repeat);

    // R6
    property p_narrow_low_zero;
        @(posedge clk) disable iff (!rst_n)
            (pad_oe && phase_o[PH_W-1] && !wide_q) |-> (pad_data[1:0] == 2'b00);
    endproperty
    narrow_low_zero_chk: assert property (p_narrow_low_zero);

    // R3
    property p_enable_at_phase0;
        @(posedge clk) disable iff (!rst_n) $rose(pad_oe) |-> (phase_o == PH_FIRST);
    endproperty
    enable_at_phase0_chk: assert property (p_enable_at_phase0);

    // R1
    property p_idle_clean;
        @(posedge clk) disable iff (!rst_n) !pad_oe |-> (pad_data == '0 && phase_o == PH_FIRST);
    endproperty
    idle_clean_chk: assert property (p_idle_clean);
endmodule

// File: tb/tb_pix_nibble_port.sv
`timescale 1ns/1ps
module tb_pix_nibble_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] res_data = '0;
    logic        res_valid = 1'b0;
    logic        mode_wide = 1'b1;
    logic        line_flag = 1'b1;
    logic [5:0]  pad_bus;
    logic [5:0]  pad_data;
    logic        pad_oe;
    logic [1:0]  phase_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pix_nibble_port dut (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
        .mode_wide(mode_wide), .line_flag(line_flag), .pad_bus(pad_bus),
        .pad_data(pad_data), .pad_oe(pad_oe), .phase_o(phase_o)
    );

    // {mode_wide, result, expected upper half, expected lower half}
    localparam int NV = 5;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 12'hABC, 6'h2A, 6'h3C},
        {1'b1, 12'h5A3, 6'h16, 6'h23},
        {1'b0, 12'h3FF, 6'h3F, 6'h3C},
        {1'b0, 12'hE96, 6'h29, 6'h18},
        {1'b1, 12'h000, 6'h00, 6'h00}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_drive(input string tag, input logic [1:0] ph, input logic [5:0] d);
        chk(pad_oe == 1'b1, {tag, " oe"}, int'(pad_oe), 1);
        chk(phase_o == ph, {tag, " phase R4"}, int'(phase_o), int'(ph));
        chk(pad_data == d, {tag, " data"}, int'(pad_data), int'(d));
        chk(pad_bus == d, {tag, " bus R10"}, int'(pad_bus), int'(d));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pad_oe == 1'b0, "R1 oe in reset", int'(pad_oe), 0);
        chk(phase_o == 2'd0, "R1 phase in reset", int'(phase_o), 0);
        chk(pad_data == 6'd0, "R1 data in reset", int'(pad_data), 0);
        rst_n = 1'b1;

        // Vector table walk: R3 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            line_flag = 1'b1;
            res_valid = 1'b0;
            @(negedge clk);
            chk(pad_oe == 1'b0, "R2 oe low while line high", int'(pad_oe), 0);
            chk(phase_o == 2'd0, "R2 phase zero while line high", int'(phase_o), 0);
            line_flag = 1'b0;
            mode_wide = VEC[i][24];
            res_data  = VEC[i][23:12];
            res_valid = 1'b1;
            @(negedge clk);
            chk_drive("R3 R5 R6 phase0", 2'd0, VEC[i][11:6]);
            res_valid = 1'b0;
            res_data  = 12'h555;
            mode_wide = ~VEC[i][24];
            @(negedge clk);
            chk_drive("R7 phase1", 2'd1, VEC[i][11:6]);
            @(negedge clk);
            chk_drive("R5 R6 phase2", 2'd2, VEC[i][5:0]);
            @(negedge clk);
            chk_drive("R7 phase3", 2'd3, VEC[i][5:0]);
            mode_wide = VEC[i][24];
        end

        // R8 back-to-back: new word taken at the wrap (now in phase 3, wide mode)
        mode_wide = 1'b1;
        res_data  = 12'h801;
        res_valid = 1'b1;
        @(negedge clk);
        chk_drive("R8 wrap load", 2'd0, 6'h20);
        // R8 strobe mid-word ignored
        res_data  = 12'hFFF;
        mode_wide = 1'b0;
        @(negedge clk);
        chk_drive("R8 mid strobe ignored p1", 2'd1, 6'h20);
        @(negedge clk);
        chk_drive("R8 mid strobe ignored p2", 2'd2, 6'h01);
        @(negedge clk);
        chk_drive("R8 mid strobe ignored p3", 2'd3, 6'h01);
        // R9 no strobe at wrap: old word repeated
        res_valid = 1'b0;
        mode_wide = 1'b1;
        @(negedge clk);
        chk_drive("R9 repeat p0", 2'd0, 6'h20);
        @(negedge clk);
        @(negedge clk);
        chk_drive("R9 repeat p2", 2'd2, 6'h01);
        // R2 line rises mid-word
        line_flag = 1'b1;
        @(negedge clk);
        chk(pad_oe == 1'b0, "R2 oe off mid-word", int'(pad_oe), 0);
        chk(phase_o == 2'd0, "R2 phase reset mid-word", int'(phase_o), 0);
        chk(pad_data == 6'd0, "R2 data cleared", int'(pad_data), 0);
        // R3 resume: held word driven again from phase 0
        line_flag = 1'b0;
        @(negedge clk);
        chk_drive("R3 resume phase0", 2'd0, 6'h20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule